// File: doc/BRIEF.md
# Frame-Cadence UART Transmitter

This block sends bytes as asynchronous serial characters, and it only starts a character on a fixed beat. Each byte becomes an 11-bit serial word. The word is built as `((byte << 2) & 0x3FC) | 0x401`. On the line this gives a leading high bit, a low start bit, the eight data bits least significant first, and a high stop bit. An internal frame counter fires once every 13 bit periods. A word can begin only on that beat, so consecutive characters keep a fixed cadence with at least two idle bit periods between them.

Bytes come in through a valid/ready port into an 8-entry holding buffer. A programmable divider sets the bit period to `2*(div+1)` system clocks. The enable input starts the bit and frame timing. Clearing it lets the word in flight finish, and then the block stops launching new words. A frame with nothing to send is skipped, and the line stays high. The holding-empty output describes the buffer only. It rises as soon as the last byte has been taken into the shifter, not when the line goes idle.

Top module: `fsync_uart_tx`

## Requirements
- R1: Each character appears on `tx_out` as high, start bit low, data bits 0 through 7 in that order, then a high stop bit. Each of these is one bit period long.
- R2: A bit period lasts exactly `2*(div+1)` clock cycles, and `tx_out` changes only at bit-period boundaries.
- R3: While enable stays high, the start bits of successive characters are a whole multiple of 13 bit periods apart, and never fewer than 13. The two bit periods after each stop bit are high.
- R4: Consider enable rising from a fully idle state with a byte already held. Let the first clock edge that samples enable high be edge 1. The start bit then appears on `tx_out` right after clock edge `14*P`, where `P = 2*(div+1)`. The leading high bit occupies the period before it.
- R5: A frame beat that finds the buffer empty launches nothing and raises no error. The next character starts on a later beat.
- R6: Whenever no word is being shifted, including while disabled, `tx_out` is high.
- R7: The buffer holds up to 8 bytes. `in_ready` is low when 8 bytes are waiting. Bytes leave in the order they were accepted.
- R8: `hold_empty` is high when the buffer is empty, even while the last word is still being shifted out.
- R9: Clearing enable during a word lets that word complete. After that no word is launched while enable is low, and held bytes stay held.
- R10: During and just after reset, `tx_out` is high, `hold_empty` is high and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Transmit enable; starts bit and frame timing |
| div | input | DIV_W | Bit-period divider; period is 2*(div+1) clocks |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | Holding buffer can take a byte |
| tx_out | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding buffer has no bytes waiting |

## Verification
The hardest case to reach from the ports is enable being dropped in the middle of a word while another byte is still held. The word in flight must finish, and the held byte must then stay put rather than leak out on the next frame beat. The stimulus loads two bytes and enables the block. It waits for the first start bit, drops enable three bit periods later, and then watches the line and the holding status for thirty bit periods. After that it re-enables the block and expects the second byte. A second hard case is the exact enable-to-start latency. The stimulus holds a byte with the block disabled, raises enable at a known edge, and samples the line on both sides of the predicted start-bit edge.

// File: rtl/fsync_uart_pkg.sv
// Shared constants and word construction for the frame-cadence transmitter.
// Assumes 8-bit characters with one leading idle bit and one stop bit.
package fsync_uart_pkg;
    localparam int DATA_BITS  = 8;
    localparam int WORD_BITS  = DATA_BITS + 3;
    localparam int FRAME_DFLT = 13;

    // Wrap a byte: bit0 idle high, bit1 start low, data, top bit stop high.
    function automatic logic [WORD_BITS-1:0] make_word(input logic [DATA_BITS-1:0] b);
        return {1'b1, b, 1'b0, 1'b1};
    endfunction
endpackage

// File: rtl/fsut_bitclk.sv
// Bit-period enable generator: pulses bit_tick once every 2*(div+1) clocks.
// Assumes div is only changed while run is low; the counter restarts from
// zero whenever run is low so timing after enable is deterministic.
module fsut_bitclk #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             bit_tick
);
    logic [DIV_W:0] cnt;
    logic [DIV_W:0] last;

    assign last     = {div, 1'b1};
    assign bit_tick = run && (cnt == last);

    // Count clocks within one bit period, restarting while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)    cnt <= '0;
        else if (cnt == last)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/fsut_hold_fifo.sv
// Holding buffer: small circular FIFO with registered count.
// Assumes the caller never pushes when full nor pops when empty.
module fsut_hold_fifo #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              full,
    output logic              empty,
    output logic [CNT_W-1:0]  count
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign dout  = mem[rd_ptr];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    // Store an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Advance pointers and occupancy on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/fsut_framer.sv
// Frame scheduler and shifter: counts bit periods into frames and, on the
// last bit of a frame, loads a pending word and drives it LSB first.
// Assumes bit_tick only pulses while run is high; tx idles high.
module fsut_framer #(
    parameter int FRAME_BITS = 13,
    parameter int WORD_BITS  = 11,
    localparam int FCNT_W = $clog2(FRAME_BITS),
    localparam int IDX_W  = $clog2(WORD_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 en,
    input  logic                 bit_tick,
    input  logic                 pending,
    input  logic [WORD_BITS-1:0] word,
    output logic                 launch,
    output logic                 active,
    output logic                 tx
);
    logic [FCNT_W-1:0]    fcnt;
    logic [WORD_BITS-1:0] shreg;
    logic [IDX_W-1:0]     idx;
    logic                 frame_edge;

    assign frame_edge = bit_tick && (fcnt == FCNT_W'(FRAME_BITS - 1));
    assign launch     = frame_edge && en && pending && !active;

    // Position of the current bit period within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) fcnt <= '0;
        else if (bit_tick)  fcnt <= (fcnt == FCNT_W'(FRAME_BITS - 1)) ? '0 : fcnt + 1'b1;
    end

    // Load on launch, then shift one bit per bit period until the stop bit ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            idx    <= '0;
            active <= 1'b0;
            tx     <= 1'b1;
        end else if (launch) begin
            shreg  <= word >> 1;
            tx     <= word[0];
            idx    <= '0;
            active <= 1'b1;
        end else if (bit_tick && active) begin
            if (idx == IDX_W'(WORD_BITS - 1)) begin
                active <= 1'b0;
                tx     <= 1'b1;
            end else begin
                tx    <= shreg[0];
                shreg <= shreg >> 1;
                idx   <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fsync_uart_tx.sv
// Frame-cadence UART transmitter top: holding buffer, bit-period divider and
// frame scheduler/shifter. Assumes div changes only while idle and disabled.
module fsync_uart_tx
    import fsync_uart_pkg::*;
#(
    parameter int DIV_W      = 12,
    parameter int HOLD_DEPTH = 8,
    parameter int FRAME_BITS = FRAME_DFLT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             tx_out,
    output logic             hold_empty
);
    localparam int CNT_W = $clog2(HOLD_DEPTH + 1);

    logic                 bit_tick;
    logic                 launch;
    logic                 active;
    logic                 running;
    logic                 fifo_full;
    logic                 fifo_empty;
    logic [7:0]           head;
    logic [CNT_W-1:0]     fifo_cnt;
    logic [WORD_BITS-1:0] head_word;

    assign running    = en | active;
    assign in_ready   = !fifo_full;
    assign hold_empty = fifo_empty;
    assign head_word  = make_word(head);

    fsut_hold_fifo #(.DEPTH(HOLD_DEPTH), .DATA_W(8)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (in_valid && !fifo_full),
        .din   (in_data),
        .pop   (launch),
        .dout  (head),
        .full  (fifo_full),
        .empty (fifo_empty),
        .count (fifo_cnt)
    );

    fsut_bitclk #(.DIV_W(DIV_W)) u_bitclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .div      (div),
        .bit_tick (bit_tick)
    );

    fsut_framer #(.FRAME_BITS(FRAME_BITS), .WORD_BITS(WORD_BITS)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .en       (en),
        .bit_tick (bit_tick),
        .pending  (!fifo_empty),
        .word     (head_word),
        .launch   (launch),
        .active   (active),
        .tx       (tx_out)
    );
endmodule

// File: rtl/fsync_uart_tx_chk.sv
// Protocol checker for fsync_uart_tx, attached by bind.
// Assumes the synchronous active-low reset is asserted at time zero.
module fsync_uart_tx_chk #(
    parameter int FRAME_BITS = 13,
    parameter int HOLD_DEPTH = 8,
    localparam int CNT_W = $clog2(HOLD_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             tx_out,
    input logic             hold_empty,
    input logic             bit_tick,
    input logic             launch,
    input logic             active,
    input logic [CNT_W-1:0] fifo_cnt
);
    logic [5:0] since_launch;

    // Bit periods elapsed since the last launch, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                          since_launch <= 6'd63;
        else if (launch)                     since_launch <= '0;
        else if (bit_tick && since_launch != 6'd63) since_launch <= since_launch + 1'b1;
    end

    p_reset_idle_r10: assert property (@(posedge clk) !rst_n |=> tx_out);

    p_tx_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(tx_out));

    p_launch_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (since_launch >= 6'(FRAME_BITS - 1)));

    p_launch_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !hold_empty);

    p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> tx_out);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(HOLD_DEPTH));

    p_no_launch_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !launch);
endmodule

bind fsync_uart_tx fsync_uart_tx_chk #(
    .FRAME_BITS (FRAME_BITS),
    .HOLD_DEPTH (HOLD_DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .tx_out     (tx_out),
    .hold_empty (hold_empty),
    .bit_tick   (bit_tick),
    .launch     (launch),
    .active     (active),
    .fifo_cnt   (fifo_cnt)
);

// File: tb/fsync_uart_tx_bench.sv
// Scoreboard bench: push_byte queues expected bytes, a line monitor decodes
// characters from tx_out and compares them in order.
module fsync_uart_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [11:0] div = '0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        tx_out;
    logic        hold_empty;

    int          n_checks = 0;
    int          n_fails  = 0;
    int          cyc = 0;
    int          P = 2;
    int          last_start = 0;
    bit          last_valid = 1'b0;
    logic [7:0]  exp_q [$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fsync_uart_tx u_fsync_uart_tx (
        .clk(clk), .rst_n(rst_n), .en(en), .div(div), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .tx_out(tx_out),
        .hold_empty(hold_empty)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_data  = b;
        in_valid = 1'b1;
        exp_q.push_back(b);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_drained();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3 * P) @(negedge clk);
    endtask

    // Line monitor: decode each character and compare against the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tx_out === 1'b0) begin
                int         t0;
                int         p;
                logic [7:0] got;
                logic [7:0] want;
                t0 = cyc;
                p  = P;
                if (last_valid)
                    check(((t0 - last_start) % (13 * p) == 0) && ((t0 - last_start) >= 13 * p),
                          "R3 R5 start spacing", t0 - last_start, 13 * p);
                last_start = t0;
                last_valid = 1'b1;
                repeat (p - 1) @(negedge clk);
                check(tx_out === 1'b0, "R2 start bit width", int'(tx_out), 0);
                for (int k = 0; k < 8; k++) begin
                    repeat ((k == 0) ? 1 : p) @(negedge clk);
                    got[k] = tx_out;
                end
                repeat (p) @(negedge clk);
                check(tx_out === 1'b1, "R1 stop bit", int'(tx_out), 1);
                repeat (p) @(negedge clk);
                begin
                    logic g0;
                    g0 = tx_out;
                    repeat (p) @(negedge clk);
                    check(g0 === 1'b1 && tx_out === 1'b1, "R3 idle gap", int'(g0 & tx_out), 1);
                end
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected character", int'(got), -1);
                end else begin
                    want = exp_q.pop_front();
                    check(got === want, "R1 R7 data order", int'(got), int'(want));
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check(tx_out === 1'b1, "R10 tx high in reset", int'(tx_out), 1);
        check(hold_empty === 1'b1, "R10 hold_empty in reset", int'(hold_empty), 1);
        check(in_ready === 1'b1, "R10 in_ready in reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_out === 1'b1, "R10 tx high after reset", int'(tx_out), 1);

        // R1 R3: back-to-back characters at div=0
        div = 12'd0; P = 2;
        en = 1'b1;
        push_byte(8'hA5);
        push_byte(8'h3C);
        push_byte(8'h00);
        push_byte(8'hFF);
        wait_drained();

        // R8 R5: single byte, holding status clears while shifting
        repeat (5) @(negedge clk);
        push_byte(8'h81);
        while (tx_out !== 1'b0) @(negedge clk);
        check(hold_empty === 1'b1, "R8 hold_empty during shift", int'(hold_empty), 1);
        wait_drained();

        // R4 R6: enable latency from idle, byte pending while disabled
        en = 1'b0;
        repeat (20) @(negedge clk);
        div = 12'd1; P = 4;
        last_valid = 1'b0;
        push_byte(8'h5A);
        begin
            bit all_high;
            all_high = 1'b1;
            repeat (30) begin
                @(negedge clk);
                if (tx_out !== 1'b1) all_high = 1'b0;
            end
            check(all_high, "R6 line high while disabled", int'(all_high), 1);
        end
        check(hold_empty === 1'b0, "R9 byte held while disabled", int'(hold_empty), 0);
        en = 1'b1;
        repeat (14 * P - 1) @(negedge clk);
        check(tx_out === 1'b1, "R4 leading bit before start", int'(tx_out), 1);
        @(negedge clk);
        check(tx_out === 1'b0, "R4 start bit timing", int'(tx_out), 0);
        wait_drained();

        // R7: fill the buffer while disabled, then drain in order
        en = 1'b0;
        repeat (4 * P) @(negedge clk);
        last_valid = 1'b0;
        for (int i = 0; i < 8; i++) push_byte(8'(8'h10 + i * 17));
        check(in_ready === 1'b0, "R7 ready low when full", int'(in_ready), 0);
        check(hold_empty === 1'b0, "R7 hold not empty when full", int'(hold_empty), 0);
        en = 1'b1;
        wait_drained();
        check(in_ready === 1'b1, "R7 ready after drain", int'(in_ready), 1);

        // R9: drop enable mid-word with a second byte held
        en = 1'b0;
        repeat (4 * P) @(negedge clk);
        div = 12'd2; P = 6;
        last_valid = 1'b0;
        push_byte(8'hC3);
        push_byte(8'h96);
        en = 1'b1;
        while (tx_out !== 1'b0) @(negedge clk);
        repeat (3 * P) @(negedge clk);
        en = 1'b0;
        last_valid = 1'b0;
        while (exp_q.size() > 1) @(negedge clk);
        begin
            bit quiet;
            quiet = 1'b1;
            repeat (30 * P) begin
                @(negedge clk);
                if (tx_out !== 1'b1) quiet = 1'b0;
            end
            check(quiet, "R9 no launch while disabled", int'(quiet), 1);
        end
        check(hold_empty === 1'b0, "R9 second byte still held", int'(hold_empty), 0);
        check(exp_q.size() == 1, "R9 first word completed", exp_q.size(), 1);
        en = 1'b1;
        wait_drained();
        check(hold_empty === 1'b1, "R8 empty after drain", int'(hold_empty), 1);

        finish_run();
    end
endmodule